// File: doc/BRIEF.md
# I2C Master SCL Period Generator

This block produces the serial clock of an I2C master from a fast reference clock. Two pairs of period counts are provided, one pair for standard mode and one for fast mode, and a mode input picks the pair. The block drives SCL in open-drain style: the output requests a pull-low, and releasing it lets the line float high. It reads the line back, so a target that stretches the clock, or a line that rises slowly, delays the high-period count until the line is actually seen high.

A bit engine uses the block by requesting a START, watching the phase strobes, and requesting a STOP. The block times the START hold (SCL high after SDA has fallen), alternates low and high periods, and after a STOP request closes the transfer with a release period. It gives a mid-high strobe for sampling SDA, a falling-edge strobe for shifting the next SDA value, and a strobe that marks the point at which SDA may be released for the STOP. The period counts and the mode are taken in only while the controller reports itself disabled. The reported enable status follows the request only when no transfer is in progress.

Top module: `scl_timing_gen`

## Requirements
- R1: `fast_mode`=1 selects the `fast_high_cnt`/`fast_low_cnt` pair and `fast_mode`=0 selects the `std_high_cnt`/`std_low_cnt` pair. H and L below are the selected high and low counts after R6.
- R2: Each low period holds `scl_drive_low`=1 for exactly L+1 reference cycles, counted from the first cycle the pull-low is asserted.
- R3: Each high period releases SCL until H+8 rising clock edges have seen `scl_in`=1; with no stretching the release lasts exactly H+8 cycles.
- R4: Cycles in which `scl_in` reads 0 while SCL is released are not counted, so a stretch of S cycles lengthens that high period to S+H+8 cycles.
- R5: After an accepted START the block keeps SCL released for exactly H+3 cycles before the first pull-low.
- R6: A selected high count below 6 is used as 6 and a selected low count below 8 is used as 8.
- R7: Counts and mode are captured only while `enable_status`=0; changing them while `enable_status`=1 does not alter any period.
- R8: `enable_status` takes the value of `enable_req` one cycle after a cycle in which no transfer is active, and holds while a transfer is active; `start_req` has no effect while `enable_status`=0, and `scl_drive_low` is never 1 while `enable_status`=0.
- R9: `sample_stb` is 1 for exactly one cycle per high period, in the released cycle with index S+floor((H+8)/2), counting the first released cycle as 0.
- R10: `shift_stb` is 1 in exactly the first cycle of each low period.
- R11: A `stop_req` pulse at any time during a transfer ends it after the current or next low period: SCL is then released for H+3 counted cycles, `stop_stb` is 1 in the last of them, and SCL stays released afterwards.
- R12: During and right after reset `scl_drive_low`, `enable_status` and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable_req | input | 1 | Controller enable request |
| fast_mode | input | 1 | 1 = fast-mode count pair, 0 = standard-mode pair |
| std_high_cnt | input | CNT_W | Standard-mode high count |
| std_low_cnt | input | CNT_W | Standard-mode low count |
| fast_high_cnt | input | CNT_W | Fast-mode high count |
| fast_low_cnt | input | CNT_W | Fast-mode low count |
| start_req | input | 1 | Begin a transfer (honoured only when idle and enabled) |
| stop_req | input | 1 | End the transfer after a low period |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release |
| enable_status | output | 1 | Enable state actually in force |
| sample_stb | output | 1 | One-cycle strobe in the middle of a high period |
| shift_stb | output | 1 | One-cycle strobe at each SCL fall |
| stop_stb | output | 1 | One-cycle strobe at the end of the STOP release |

## Verification
The bench builds the block with its default count width of 16 bits but draws counts from 0 to 30, so values under the minimums, values just above them, and both odd and even H (which moves the mid-high strobe) all occur within short frames. Clock stretch of up to four cycles is modelled by holding the bench's wired SCL low after release, which reaches the uncounted-cycle path and the shifted strobe position. Directed frames change every count input mid-transfer, drop the enable during a transfer, and pulse START while disabled.

// File: rtl/scl_timing_pkg.sv
// Shared constants, phase type and clamp helper for the SCL period generator.
// Assumes counts are unsigned and wide enough to hold the minimum values.
package scl_timing_pkg;

    // Fixed cycle overheads added to the programmed counts.
    localparam int HIGH_OVERHEAD  = 8;
    localparam int LOW_OVERHEAD   = 1;
    localparam int SETTLE_OVERHEAD = 3;

    // Floors applied to the programmed counts.
    localparam int MIN_HIGH = 6;
    localparam int MIN_LOW  = 8;

    // Number of speed modes with their own count pair.
    localparam int NUM_MODES = 2;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_START  = 3'd1,
        PH_LOW    = 3'd2,
        PH_HIGH   = 3'd3,
        PH_STOP   = 3'd4
    } phase_e;

endpackage

// File: rtl/scl_cfg_shadow.sv
// Configuration shadow: clamps each mode's counts to their floors, selects the
// pair for the requested mode and holds it while the controller is enabled.
// Assumes 'capture' is high exactly while the controller reports disabled.
module scl_cfg_shadow
    import scl_timing_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             fast_mode,
    input  logic [CNT_W-1:0] std_high_cnt,
    input  logic [CNT_W-1:0] std_low_cnt,
    input  logic [CNT_W-1:0] fast_high_cnt,
    input  logic [CNT_W-1:0] fast_low_cnt,
    output logic [CNT_W-1:0] high_eff,
    output logic [CNT_W-1:0] low_eff
);

    localparam logic [CNT_W-1:0] HIGH_FLOOR = CNT_W'(MIN_HIGH);
    localparam logic [CNT_W-1:0] LOW_FLOOR  = CNT_W'(MIN_LOW);

    logic [CNT_W-1:0] raw_high   [NUM_MODES];
    logic [CNT_W-1:0] raw_low    [NUM_MODES];
    logic [CNT_W-1:0] floor_high [NUM_MODES];
    logic [CNT_W-1:0] floor_low  [NUM_MODES];

    // Gather per-mode count inputs (index 1 = fast mode).
    always_comb begin
        raw_high[0] = std_high_cnt;
        raw_low[0]  = std_low_cnt;
        raw_high[1] = fast_high_cnt;
        raw_low[1]  = fast_low_cnt;
    end

    // Apply the floors separately for every mode.
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_clamp
        assign floor_high[m] = (raw_high[m] < HIGH_FLOOR) ? HIGH_FLOOR : raw_high[m];
        assign floor_low[m]  = (raw_low[m]  < LOW_FLOOR)  ? LOW_FLOOR  : raw_low[m];
    end

    // Capture the selected pair only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_eff <= HIGH_FLOOR;
            low_eff  <= LOW_FLOOR;
        end else if (capture) begin
            high_eff <= floor_high[fast_mode];
            low_eff  <= floor_low[fast_mode];
        end
    end

    // R6
    high_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        high_eff >= HIGH_FLOOR);

    // R6
    low_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_eff >= LOW_FLOOR);

    // R7
    frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture && !$past(capture)) |-> ($stable(high_eff) && $stable(low_eff)));

endmodule

// File: rtl/scl_phase_ctrl.sv
// Phase sequencer: walks START hold, low, high and STOP release periods,
// counting high and release cycles only while the line reads high. Owns the
// enable status, which may change only while no transfer is active.
// Assumes scl_in is already synchronised to clk.
module scl_phase_ctrl
    import scl_timing_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_req,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] high_eff,
    input  logic [CNT_W-1:0] low_eff,
    output phase_e           phase,
    output logic [CNT_W+1:0] phase_cnt,
    output logic             enable_status,
    output logic             drive_low
);

    localparam int PW = CNT_W + 2;

    logic [PW-1:0] settle_last;
    logic [PW-1:0] low_last;
    logic [PW-1:0] high_last;
    logic          stop_pend;
    logic          stop_now;

    // Last counter value of each period, widened so the overheads never wrap.
    always_comb begin
        settle_last = PW'(high_eff) + PW'(SETTLE_OVERHEAD - 1);
        low_last    = PW'(low_eff)  + PW'(LOW_OVERHEAD - 1);
        high_last   = PW'(high_eff) + PW'(HIGH_OVERHEAD - 1);
    end

    // A stop is taken from the held flag or from a request in the same cycle.
    assign stop_now = stop_pend | stop_req;

    // Enable status follows the request only between transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_status <= 1'b0;
        end else if (phase == PH_IDLE) begin
            enable_status <= enable_req;
        end
    end

    // Remember a stop request until the STOP release period begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_pend <= 1'b0;
        end else if (phase == PH_STOP || phase == PH_IDLE) begin
            stop_pend <= 1'b0;
        end else if (stop_req) begin
            stop_pend <= 1'b1;
        end
    end

    // Phase and in-phase counter sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            phase_cnt <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    phase_cnt <= '0;
                    if (enable_status && enable_req && start_req) begin
                        phase <= PH_START;
                    end
                end
                PH_START: begin
                    if (phase_cnt == settle_last) begin
                        phase     <= PH_LOW;
                        phase_cnt <= '0;
                    end else begin
                        phase_cnt <= phase_cnt + 1'b1;
                    end
                end
                PH_LOW: begin
                    if (phase_cnt == low_last) begin
                        phase     <= stop_now ? PH_STOP : PH_HIGH;
                        phase_cnt <= '0;
                    end else begin
                        phase_cnt <= phase_cnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (scl_in) begin
                        if (phase_cnt == high_last) begin
                            phase     <= PH_LOW;
                            phase_cnt <= '0;
                        end else begin
                            phase_cnt <= phase_cnt + 1'b1;
                        end
                    end
                end
                PH_STOP: begin
                    if (scl_in) begin
                        if (phase_cnt == settle_last) begin
                            phase     <= PH_IDLE;
                            phase_cnt <= '0;
                        end else begin
                            phase_cnt <= phase_cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    phase     <= PH_IDLE;
                    phase_cnt <= '0;
                end
            endcase
        end
    end

    // SCL is pulled only during low periods.
    assign drive_low = (phase == PH_LOW);

    // R8
    drive_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |-> enable_status);

    // R8
    status_change_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_status != $past(enable_status)) |-> ($past(phase) == PH_IDLE));

    // R2
    low_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOW) |-> (phase_cnt <= low_last));

    // R4
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_HIGH) && !scl_in) |=> ((phase == PH_HIGH) && $stable(phase_cnt)));

endmodule

// File: rtl/scl_strobe_gen.sv
// Phase strobes for the bit engine: mid-high sample point, fall (shift) point
// and end of the STOP release. Purely combinational from the sequencer state.
// Assumes the counter starts at zero on entry to every phase.
module scl_strobe_gen
    import scl_timing_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  phase_e           phase,
    input  logic [CNT_W+1:0] phase_cnt,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] high_eff,
    output logic             sample_stb,
    output logic             shift_stb,
    output logic             stop_stb
);

    localparam int PW = CNT_W + 2;

    logic [PW-1:0] mid_point;
    logic [PW-1:0] settle_last;

    // Mid-point of the counted high period and last counted STOP cycle.
    always_comb begin
        mid_point   = (PW'(high_eff) + PW'(HIGH_OVERHEAD)) >> 1;
        settle_last = PW'(high_eff) + PW'(SETTLE_OVERHEAD - 1);
    end

    // Decode the strobes; counted cycles need the line high.
    always_comb begin
        sample_stb = (phase == PH_HIGH) && scl_in && (phase_cnt == mid_point);
        shift_stb  = (phase == PH_LOW)  && (phase_cnt == '0);
        stop_stb   = (phase == PH_STOP) && scl_in && (phase_cnt == settle_last);
    end

endmodule

// File: rtl/scl_timing_gen.sv
// Top of the I2C master SCL period generator: config shadow, phase sequencer
// and strobe decode. Drives SCL open-drain style through scl_drive_low.
// Assumes scl_in is synchronised to clk by the pad logic.
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_req,
    input  logic             fast_mode,
    input  logic [CNT_W-1:0] std_high_cnt,
    input  logic [CNT_W-1:0] std_low_cnt,
    input  logic [CNT_W-1:0] fast_high_cnt,
    input  logic [CNT_W-1:0] fast_low_cnt,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             enable_status,
    output logic             sample_stb,
    output logic             shift_stb,
    output logic             stop_stb
);

    logic [CNT_W-1:0] high_eff;
    logic [CNT_W-1:0] low_eff;
    phase_e           phase;
    logic [CNT_W+1:0] phase_cnt;

    scl_cfg_shadow #(.CNT_W(CNT_W)) i_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture      (!enable_status),
        .fast_mode    (fast_mode),
        .std_high_cnt (std_high_cnt),
        .std_low_cnt  (std_low_cnt),
        .fast_high_cnt(fast_high_cnt),
        .fast_low_cnt (fast_low_cnt),
        .high_eff     (high_eff),
        .low_eff      (low_eff)
    );

    scl_phase_ctrl #(.CNT_W(CNT_W)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_req   (enable_req),
        .start_req    (start_req),
        .stop_req     (stop_req),
        .scl_in       (scl_in),
        .high_eff     (high_eff),
        .low_eff      (low_eff),
        .phase        (phase),
        .phase_cnt    (phase_cnt),
        .enable_status(enable_status),
        .drive_low    (scl_drive_low)
    );

    scl_strobe_gen #(.CNT_W(CNT_W)) i_stb (
        .phase     (phase),
        .phase_cnt (phase_cnt),
        .scl_in    (scl_in),
        .high_eff  (high_eff),
        .sample_stb(sample_stb),
        .shift_stb (shift_stb),
        .stop_stb  (stop_stb)
    );

    // R10
    shift_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> shift_stb);

    // R9
    sample_when_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (!scl_drive_low && scl_in));

    // R11
    stop_then_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_stb |=> !scl_drive_low);

    // R9
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample_stb, shift_stb, stop_stb}));

endmodule

// File: tb/test_scl_timing_gen.sv
`timescale 1ns/1ps
module test_scl_timing_gen;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable_req = 1'b0;
    logic             fast_mode = 1'b0;
    logic [CNT_W-1:0] std_high_cnt = '0;
    logic [CNT_W-1:0] std_low_cnt = '0;
    logic [CNT_W-1:0] fast_high_cnt = '0;
    logic [CNT_W-1:0] fast_low_cnt = '0;
    logic             start_req = 1'b0;
    logic             stop_req = 1'b0;
    logic             stretch = 1'b0;
    logic             scl_in;
    logic             scl_drive_low;
    logic             enable_status;
    logic             sample_stb;
    logic             shift_stb;
    logic             stop_stb;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Wired SCL: pulled by the block or held low by a stretching target.
    assign scl_in = !(scl_drive_low || stretch);

    always #2 clk = !clk;

    scl_timing_gen #(.CNT_W(CNT_W)) i_scl_timing_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_req   (enable_req),
        .fast_mode    (fast_mode),
        .std_high_cnt (std_high_cnt),
        .std_low_cnt  (std_low_cnt),
        .fast_high_cnt(fast_high_cnt),
        .fast_low_cnt (fast_low_cnt),
        .start_req    (start_req),
        .stop_req     (stop_req),
        .scl_in       (scl_in),
        .scl_drive_low(scl_drive_low),
        .enable_status(enable_status),
        .sample_stb   (sample_stb),
        .shift_stb    (shift_stb),
        .stop_stb     (stop_stb)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int floor_of(input int v, input int lo);
        return (v < lo) ? lo : v;
    endfunction

    task automatic wait_disabled();
        int guard = 0;
        enable_req = 1'b0;
        @(negedge clk);
        while (enable_status && guard < 5000) begin
            guard++;
            @(negedge clk);
        end
    endtask

    // One full transfer: START, nbits low periods, STOP; measures every period.
    task automatic do_frame(input int sh, input int sl, input int fh, input int fl,
                            input bit fm, input int nbits, input int s_len,
                            input bit mutate, input bit drop_en);
        int h_exp, l_exp, n, k, seen, hits, stb_at, guard;
        bit bad_drive;
        h_exp = floor_of(fm ? fh : sh, 6);
        l_exp = floor_of(fm ? fl : sl, 8);
        wait_disabled();
        std_high_cnt  = CNT_W'(sh);
        std_low_cnt   = CNT_W'(sl);
        fast_high_cnt = CNT_W'(fh);
        fast_low_cnt  = CNT_W'(fl);
        fast_mode     = fm;
        @(negedge clk);
        enable_req = 1'b1;
        @(negedge clk);
        check(enable_status == 1'b1, "R8", "status after enable", int'(enable_status), 1);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        if (mutate) begin
            std_high_cnt  = CNT_W'(sh + 13);
            std_low_cnt   = CNT_W'(sl + 17);
            fast_high_cnt = CNT_W'(fh + 11);
            fast_low_cnt  = CNT_W'(fl + 19);
            fast_mode     = !fm;
        end
        // START hold
        n = 0;
        while (!scl_drive_low && n < 5000) begin
            n++;
            @(negedge clk);
        end
        check(n == h_exp + 3, "R5", "start hold cycles", n, h_exp + 3);
        for (int b = 0; b < nbits; b++) begin
            // low period (R1 and R7 via the selected, frozen count)
            n = 0;
            check(shift_stb == 1'b1, "R10", "shift strobe at fall", int'(shift_stb), 1);
            if (drop_en && b == nbits - 1) enable_req = 1'b0;
            while (scl_drive_low && n < 5000) begin
                stop_req = (b == nbits - 1) && (n == 0);
                if (n > 0 && shift_stb) check(1'b0, "R10", "shift strobe late", n, 0);
                n++;
                @(negedge clk);
            end
            stop_req = 1'b0;
            check(n == l_exp + 1, mutate ? "R7" : "R2", "low cycles", n, l_exp + 1);
            if (b < nbits - 1) begin
                k = 0; seen = -1; hits = 0;
                while (!scl_drive_low && k < 5000) begin
                    stretch = (k < s_len);
                    #1;
                    if (sample_stb) begin
                        hits++;
                        seen = k;
                    end
                    k++;
                    @(negedge clk);
                end
                stretch = 1'b0;
                check(k == s_len + h_exp + 8, (s_len > 0) ? "R4" : "R3", "high cycles",
                      k, s_len + h_exp + 8);
                check(hits == 1 && seen == s_len + (h_exp + 8) / 2, "R9", "sample index",
                      seen, s_len + (h_exp + 8) / 2);
            end
        end
        // STOP release
        check(enable_status == 1'b1, "R8", "status held in transfer", int'(enable_status), 1);
        stb_at = -1; bad_drive = 1'b0; guard = 0;
        for (int i = 0; i < h_exp + 7; i++) begin
            if (stop_stb) stb_at = i;
            if (scl_drive_low) bad_drive = 1'b1;
            @(negedge clk);
        end
        check(stb_at == h_exp + 2, "R11", "stop strobe index", stb_at, h_exp + 2);
        check(!bad_drive, "R11", "SCL released after stop", int'(bad_drive), 0);
        check(enable_status == !drop_en, "R8", "status after transfer",
              int'(enable_status), int'(!drop_en));
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        bit drove;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R12 reset state
        check(!scl_drive_low && !enable_status, "R12", "outputs in reset",
              int'({scl_drive_low, enable_status}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!scl_drive_low && !enable_status && !sample_stb && !shift_stb && !stop_stb,
              "R12", "outputs after reset",
              int'({scl_drive_low, enable_status, sample_stb, shift_stb, stop_stb}), 0);

        // R8: START while disabled is ignored
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        drove = 1'b0;
        for (int i = 0; i < 30; i++) begin
            if (scl_drive_low) drove = 1'b1;
            @(negedge clk);
        end
        check(!drove && !enable_status, "R8", "start ignored while disabled", int'(drove), 0);

        // Directed corners
        do_frame(0, 0, 40, 40, 1'b0, 2, 0, 1'b0, 1'b0);    // R6 floors, std pair
        do_frame(40, 40, 2, 3, 1'b1, 2, 0, 1'b0, 1'b0);    // R6 floors, fast pair (R1)
        do_frame(7, 9, 25, 30, 1'b0, 3, 3, 1'b0, 1'b0);    // R1 std, R4 stretch
        do_frame(25, 30, 7, 9, 1'b1, 3, 2, 1'b0, 1'b0);    // R1 fast
        do_frame(12, 14, 20, 22, 1'b0, 2, 0, 1'b1, 1'b0);  // R7 mid-transfer changes
        do_frame(10, 10, 10, 10, 1'b1, 2, 1, 1'b0, 1'b1);  // R8 enable dropped
        do_frame(6, 8, 6, 8, 1'b0, 1, 0, 1'b0, 1'b0);      // R11 stop on first low

        // Random frames
        for (int f = 0; f < 24; f++) begin
            do_frame(int'($urandom_range(0, 30)), int'($urandom_range(0, 30)),
                     int'($urandom_range(0, 30)), int'($urandom_range(0, 30)),
                     1'($urandom_range(0, 1)), int'($urandom_range(1, 3)),
                     int'($urandom_range(0, 4)), 1'($urandom_range(0, 1)), 1'b0);
        end

        // Idle stays released after everything (R11)
        n = 0;
        for (int i = 0; i < 10; i++) begin
            if (scl_drive_low) n++;
            @(negedge clk);
        end
        check(n == 0, "R11", "idle released", n, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule